// File: doc/BRIEF.md
# Three-Group Priority Interrupt Encoder

This block gathers interrupt requests from three groups (critical, main and peripheral) and folds them into one encoded status word and one resolved 8-bit interrupt identifier. The identifier holds a 2-bit group number in bits [7:6] and a 6-bit source number in bits [5:0]. The group codes are 0 for critical, 1 for main, 2 for peripheral and 3 for DMA task. The critical group has three fixed sources: external request 0, slice timer 0 and wake-up from deep sleep. The main group carries the other external requests, slice timer 1, the real-time clock, GPIO and the general-purpose timers. Every on-chip peripheral belongs to the peripheral group.

A simple read/write port gives access to three things. The first is a mask register for the main group. The second is a mask register for the peripheral group. The third is a bank of 2-bit priority settings, one per peripheral source. With these settings a peripheral can be raised into the critical field or the main field through a reserved code. Peripheral source 0 is the summary line of a 16-task DMA engine. When it wins, the block reports the lowest-numbered pending task as a group-3 identifier.

The output stage is a two-state machine. ST_QUIET means no interrupt is presented and ST_SIGNAL means one is. The transition QUIET→SIGNAL is taken when any group field is valid. The transition SIGNAL→QUIET is taken when none is valid. QUIET→QUIET and SIGNAL→SIGNAL hold the current state. The identifier register loads on the same edge as the state.

Top module: `tri_group_irq_encoder`

## Requirements
- R1: After reset, irq_req is 0 and irq_id is 0. Both mask registers read back all ones, where a mask bit of 1 blocks its source. Every priority setting reads 0. With nothing pending, the status word reads 0.
- R2: The status word holds the critical code in bits [9:8] with its valid flag in bit 10. It holds the main code in bits [20:16] with its valid flag in bit 21. It holds the peripheral code in bits [28:24] with its valid flag in bit 29. All other bits read 0. Status is read at address 0.
- R3: Critical sources 0, 1 and 2 show as codes 0, 1 and 3. Code 2 means a high-boosted peripheral is pending. The lowest pending code wins. Critical sources cannot be masked.
- R4: Main source i shows as code i when i<4 and as code i+1 otherwise. Code 4 means a medium-boosted peripheral is pending. The lowest code wins. A source whose bit is set in the main mask (address 1) is ignored.
- R5: A peripheral counts as active when its request is set and its bit in the peripheral mask (address 2) is clear. The peripheral field shows the lowest active source of the highest boost class present, where high beats medium and medium beats normal. The valid flag is set when any peripheral is active.
- R6: Peripheral i has its priority setting at address 3 + i/16, in bits [2*(i%16)+1 : 2*(i%16)]. The value 2 means high, 1 means medium, and 0 or 3 means normal. The registers read back what was written.
- R7: The identifier is (group<<6)|source. The critical field is resolved first, then the main field, then the peripheral field. When the winning field holds its boost code, the identifier is group 2 with the peripheral-field source.
- R8: When peripheral source 0 wins and a DMA task is pending, the identifier is 0xC0 | (lowest pending task). When no task is pending it is 0x80.
- R9: irq_req and irq_id follow the inputs one clock later. When nothing is valid, irq_req is 0 and irq_id is 0. irq_id never exceeds 0xD0.
- R10: Writes to address 0 and to addresses above the last priority word change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req | input | 3 | Critical group requests |
| main_req | input | NMAIN | Main group requests |
| per_req | input | NPER | Peripheral group requests |
| dma_pend | input | NDMA | DMA task pending bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq_req | output | 1 | Interrupt presented |
| irq_id | output | 8 | Resolved identifier |

## Verification
Directed patterns cover several cases, and each one separates a different kind of fault. Single critical sources expose a wrong code map. Main sources above index 3 expose a missing gap at code 4. A wake request next to a high-boosted peripheral shows whether the boost slot is ordered correctly. A medium boost placed against a lower and a higher main code shows the same for the main field. Priority value 3 must behave as normal. DMA vectors with low, top and no tasks pending check the task expansion. Sparse random requests under random masks and priorities then mix all groups, so any fault in group precedence or class selection shows up against the bench model.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
    typedef enum logic [1:0] {
        GRP_CRIT = 2'd0,
        GRP_MAIN = 2'd1,
        GRP_PERI = 2'd2,
        GRP_DMA  = 2'd3
    } grp_e;

    typedef enum logic {
        ST_QUIET,
        ST_SIGNAL
    } out_st_e;

    localparam logic [1:0] CRIT_BOOST_CODE = 2'd2;
    localparam logic [4:0] MAIN_BOOST_CODE = 5'd4;
    localparam logic [1:0] PRI_MED  = 2'd1;
    localparam logic [1:0] PRI_HIGH = 2'd2;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_MMASK  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PMASK  = 3'd2;
    localparam int A_PRIO0 = 3;
    localparam int PRIO_PER_WORD = 16;

    localparam int CRIT_LSB = 8;
    localparam int CRIT_VLD = 10;
    localparam int MAIN_LSB = 16;
    localparam int MAIN_VLD = 21;
    localparam int PERI_LSB = 24;
    localparam int PERI_VLD = 29;
endpackage

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // R5
    always_comb begin
        if (any) begin
            lowest_hit_chk: assert (req[idx] && ((req & ((W'(1) << idx) - W'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_enc_pkg::*;
#(
    parameter int NMAIN = 16,
    parameter int NPER  = 24,
    localparam int PW   = (NPER + PRIO_PER_WORD - 1) / PRIO_PER_WORD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [31:0]           status_in,
    output logic [31:0]           rd_data,
    output logic [NMAIN-1:0]      main_mask,
    output logic [NPER-1:0]       per_mask,
    output logic [NPER-1:0][1:0]  per_prio
);
    logic [PW-1:0][31:0] prio_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask <= '1;
            per_mask  <= '1;
            per_prio  <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MMASK) main_mask <= wr_data[NMAIN-1:0];
            if (wr_addr == A_PMASK) per_mask  <= wr_data[NPER-1:0];
            for (int i = 0; i < NPER; i++) begin
                if (wr_addr == ADDR_W'(A_PRIO0 + i / PRIO_PER_WORD))
                    per_prio[i] <= wr_data[2*(i%PRIO_PER_WORD) +: 2];
            end
        end
    end

    always_comb begin
        prio_word = '0;
        for (int i = 0; i < NPER; i++)
            prio_word[i/PRIO_PER_WORD][2*(i%PRIO_PER_WORD) +: 2] = per_prio[i];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STATUS) rd_data = status_in;
        if (rd_addr == A_MMASK)  rd_data[NMAIN-1:0] = main_mask;
        if (rd_addr == A_PMASK)  rd_data[NPER-1:0]  = per_mask;
        for (int k = 0; k < PW; k++) begin
            if (rd_addr == ADDR_W'(A_PRIO0 + k)) rd_data = prio_word[k];
        end
    end

    // R10
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_STATUS || int'(wr_addr) >= A_PRIO0 + PW))
        |=> ($stable(main_mask) && $stable(per_mask) && $stable(per_prio)));
endmodule

// File: rtl/tri_group_irq_encoder.sv
module tri_group_irq_encoder
    import irq_enc_pkg::*;
#(
    parameter int NMAIN = 16,
    parameter int NPER  = 24,
    parameter int NDMA  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        crit_req,
    input  logic [NMAIN-1:0]  main_req,
    input  logic [NPER-1:0]   per_req,
    input  logic [NDMA-1:0]   dma_pend,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_req,
    output logic [7:0]        irq_id
);
    localparam int MCODES = NMAIN + 1;
    localparam int MIW    = $clog2(MCODES);
    localparam int PIW    = $clog2(NPER);
    localparam int DIW    = $clog2(NDMA);

    logic [NMAIN-1:0]     main_mask;
    logic [NPER-1:0]      per_mask;
    logic [NPER-1:0][1:0] per_prio;
    logic [31:0]          status;

    logic [NMAIN-1:0] main_act;
    logic [NPER-1:0]  per_act, per_hi, per_med, per_nrm, per_sel;
    logic [3:0]       crit_vec;
    logic [MCODES-1:0] main_vec;

    logic             crit_any, main_any, per_any, dma_any, any_irq;
    logic [1:0]       crit_code;
    logic [MIW-1:0]   main_idx;
    logic [PIW-1:0]   per_idx;
    logic [DIW-1:0]   dma_idx;
    logic [4:0]       main_code, per_code;
    logic [7:0]       id_next;
    logic             use_per;
    out_st_e          state, state_nx;

    irq_cfg_regs #(.NMAIN(NMAIN), .NPER(NPER)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_in(status),
        .rd_data(rd_data), .main_mask(main_mask), .per_mask(per_mask),
        .per_prio(per_prio)
    );

    assign main_act = main_req & ~main_mask;
    assign per_act  = per_req & ~per_mask;

    for (genvar i = 0; i < NPER; i++) begin : g_cls
        assign per_hi[i]  = per_act[i] && (per_prio[i] == PRI_HIGH);
        assign per_med[i] = per_act[i] && (per_prio[i] == PRI_MED);
        assign per_nrm[i] = per_act[i] && !per_hi[i] && !per_med[i];
    end

    assign per_sel  = (|per_hi) ? per_hi : ((|per_med) ? per_med : per_nrm);
    assign crit_vec = {crit_req[2], |per_hi, crit_req[1], crit_req[0]};

    for (genvar c = 0; c < MCODES; c++) begin : g_mcode
        if (c < 4) begin : g_low
            assign main_vec[c] = main_act[c];
        end else if (c == 4) begin : g_boost
            assign main_vec[c] = |per_med;
        end else begin : g_high
            assign main_vec[c] = main_act[c-1];
        end
    end

    irq_pick_lowest #(.W(4))      i_pick_crit (.req(crit_vec), .any(crit_any), .idx(crit_code));
    irq_pick_lowest #(.W(MCODES)) i_pick_main (.req(main_vec), .any(main_any), .idx(main_idx));
    irq_pick_lowest #(.W(NPER))   i_pick_per  (.req(per_sel),  .any(per_any),  .idx(per_idx));
    irq_pick_lowest #(.W(NDMA))   i_pick_dma  (.req(dma_pend), .any(dma_any),  .idx(dma_idx));

    assign main_code = 5'(main_idx);
    assign per_code  = 5'(per_idx);
    assign any_irq   = crit_any || main_any || per_any;

    always_comb begin
        status = '0;
        status[CRIT_LSB +: 2] = crit_code;
        status[CRIT_VLD]      = crit_any;
        status[MAIN_LSB +: 5] = main_code;
        status[MAIN_VLD]      = main_any;
        status[PERI_LSB +: 5] = per_code;
        status[PERI_VLD]      = per_any;
    end

    always_comb begin
        id_next = '0;
        use_per = 1'b0;
        if (crit_any) begin
            if (crit_code == CRIT_BOOST_CODE) use_per = 1'b1;
            else id_next = {GRP_CRIT, 6'(crit_code)};
        end else if (main_any) begin
            if (main_code == MAIN_BOOST_CODE) use_per = 1'b1;
            else id_next = {GRP_MAIN, 6'(main_code)};
        end else if (per_any) begin
            use_per = 1'b1;
        end
        if (use_per) begin
            if (per_code == 5'd0 && dma_any) id_next = {GRP_DMA, 6'(dma_idx)};
            else id_next = {GRP_PERI, 6'(per_code)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:  state_nx = any_irq ? ST_SIGNAL : ST_QUIET;
            ST_SIGNAL: state_nx = any_irq ? ST_SIGNAL : ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    irq_id <= '0;
        else if (any_irq) irq_id <= id_next;
        else           irq_id <= '0;
    end

    assign irq_req = (state == ST_SIGNAL);

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq |=> irq_req);
    // R9
    quiet_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_irq |=> (!irq_req && irq_id == 8'd0));
    // R9
    id_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_id <= 8'hD0));
    // R7
    main_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id[7:6] == GRP_MAIN) |-> $past(!crit_any));
    // R8
    dma_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_id[7:6] == GRP_DMA) |-> $past(dma_any && per_any));
endmodule

// File: tb/test_tri_group_irq_encoder.sv
module test_tri_group_irq_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  crit_req = '0;
    logic [15:0] main_req = '0;
    logic [23:0] per_req = '0;
    logic [15:0] dma_pend = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_req;
    logic [7:0]  irq_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mm = '1;
    logic [23:0] pm = '1;
    logic [1:0]  pr [24];

    always #2 clk = ~clk;

    tri_group_irq_encoder i_tri_group_irq_encoder (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
        .per_req(per_req), .dma_pend(dma_pend), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        int h = -1, md = -1, n = -1, pc, c, lm = -1, mc;
        for (int i = 0; i < 24; i++) begin
            if (per_req[i] && !pm[i]) begin
                if (pr[i] == 2'd2) begin if (h < 0) h = i; end
                else if (pr[i] == 2'd1) begin if (md < 0) md = i; end
                else if (n < 0) n = i;
            end
        end
        pc = (h >= 0) ? h : ((md >= 0) ? md : n);
        if (crit_req[0]) c = 0;
        else if (crit_req[1]) c = 1;
        else if (h >= 0) c = 2;
        else if (crit_req[2]) c = 3;
        else c = -1;
        for (int i = 15; i >= 0; i--)
            if (main_req[i] && !mm[i]) lm = (i < 4) ? i : i + 1;
        mc = (md >= 0 && (lm < 0 || lm > 4)) ? 4 : lm;
        if (c >= 0)  begin s[9:8] = 2'(c);    s[10] = 1'b1; end
        if (mc >= 0) begin s[20:16] = 5'(mc); s[21] = 1'b1; end
        if (pc >= 0) begin s[28:24] = 5'(pc); s[29] = 1'b1; end
        return s;
    endfunction

    function automatic logic [7:0] m_id(input logic [31:0] s);
        bit per = 0;
        int t = -1;
        if (s[10]) begin
            if (s[9:8] == 2'd2) per = 1; else return {6'd0, s[9:8]};
        end else if (s[21]) begin
            if (s[20:16] == 5'd4) per = 1; else return {3'b010, s[20:16]};
        end else if (s[29]) per = 1;
        if (!per) return 8'h00;
        if (s[28:24] == 5'd0) begin
            for (int i = 15; i >= 0; i--) if (dma_pend[i]) t = i;
            if (t >= 0) return 8'hC0 | 8'(t);
        end
        return {3'b100, s[28:24]};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a == 3'd1) mm = d[15:0];
        if (a == 3'd2) pm = d[23:0];
        if (a == 3'd3 || a == 3'd4)
            for (int j = 0; j < 16; j++)
                if ((a - 3) * 16 + j < 24) pr[(a - 3) * 16 + j] = d[2*j +: 2];
    endtask

    task automatic apply(input string req, input logic [2:0] c, input logic [15:0] m,
                         input logic [23:0] p, input logic [15:0] d);
        logic [31:0] es;
        @(negedge clk);
        crit_req = c; main_req = m; per_req = p; dma_pend = d; rd_addr = 3'd0;
        #1;
        es = m_status();
        chk({req, " status"}, rd_data, es);
        @(posedge clk); #1;
        chk({req, " irq_req"}, {31'd0, irq_req}, {31'd0, es[10] | es[21] | es[29]});
        chk({req, " irq_id"}, {24'd0, irq_id}, {24'd0, m_id(es)});
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1 chk(req, rd_data, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) pr[i] = 2'd0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
        chk("R1 irq_id", {24'd0, irq_id}, 32'd0);
        rdchk("R1 main mask", 3'd1, 32'h0000_FFFF);
        rdchk("R1 per mask", 3'd2, 32'h00FF_FFFF);
        rdchk("R1 prio0", 3'd3, 32'd0);
        rdchk("R1 prio1", 3'd4, 32'd0);
        rdchk("R1 R2 status idle", 3'd0, 32'd0);
        // R4 masked sources ignored while reset masks hold
        apply("R4 all masked", 3'b000, 16'h00F0, 24'h0000F0, 16'd0);
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd0);
        // R3 critical code map
        apply("R3 crit src1", 3'b110, 16'h0000, 24'h0, 16'd0);
        apply("R3 crit wake", 3'b100, 16'h0001, 24'h0, 16'd0);
        // R4 main code map and mask
        apply("R4 main src4", 3'b000, 16'h0010, 24'h0, 16'd0);
        apply("R4 main src15", 3'b000, 16'h8000, 24'h0, 16'd0);
        wr(3'd1, 32'h0000_0010);
        apply("R4 masked src4", 3'b000, 16'h0030, 24'h0, 16'd0);
        wr(3'd1, 32'd0);
        // R5 peripheral normal
        apply("R5 per src7", 3'b000, 16'h0, 24'h000280, 16'd0);
        // R6 R7 high boost beats wake
        wr(3'd3, 32'h0008_0000);
        apply("R7 high boost", 3'b100, 16'h0, 24'h000280, 16'd0);
        // R6 medium boost on source 20
        wr(3'd4, 32'h0000_0100);
        rdchk("R6 prio1 readback", 3'd4, 32'h0000_0100);
        apply("R7 medium boost", 3'b000, 16'h0040, 24'h100080, 16'd0);
        apply("R7 main beats medium", 3'b000, 16'h0004, 24'h100080, 16'd0);
        wr(3'd3, 32'h000C_0000);
        apply("R6 prio3 normal", 3'b000, 16'h0, 24'h000280, 16'd0);
        // R8 DMA expansion
        apply("R8 dma low task", 3'b000, 16'h0, 24'h000021, 16'h8010);
        apply("R8 dma top task", 3'b000, 16'h0, 24'h000001, 16'h8000);
        apply("R8 dma none", 3'b000, 16'h0, 24'h000001, 16'h0000);
        // R10 ignored writes
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rdchk("R10 main mask", 3'd1, 32'd0);
        rdchk("R10 per mask", 3'd2, 32'd0);
        rdchk("R10 prio0", 3'd3, 32'h000C_0000);
        rdchk("R10 prio1", 3'd4, 32'h0000_0100);
        // R9 latency and quiet
        @(negedge clk);
        per_req = 24'h000008; crit_req = '0; main_req = '0; dma_pend = '0;
        apply("R9 quiet", 3'b000, 16'h0, 24'h0, 16'h0);
        @(negedge clk);
        per_req = 24'h000008;
        #1 chk("R9 latency", {31'd0, irq_req}, 32'd0);
        // R2 R5 R7 random mix
        for (int it = 0; it < 800; it++) begin
            if (it % 40 == 0) begin
                wr(3'd1, $urandom & $urandom);
                wr(3'd2, $urandom & $urandom);
                wr(3'd3, $urandom);
                wr(3'd4, $urandom);
            end
            apply("R2 R7 random", 3'($urandom & $urandom & $urandom),
                  16'($urandom & $urandom & $urandom), 24'($urandom & $urandom & $urandom),
                  16'($urandom & $urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule